// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a free-running up-counter. The counter advances once per pulse of a slow tick enable, supplied as a one-cycle strobe in the block's clock domain. It advances only while the enable bit is set and while the debug-halt input is low. Software restarts the count by writing the service register. Three programmable thresholds judge that write and the count itself, and each threshold has its own action bit. A service that arrives below the lower limit is an early-service fault. A count that reaches the upper limit without a service is a late-service fault. Either fault produces a one-cycle reset pulse and clears the counter. A count that steps onto the warning limit sets a sticky interrupt flag.

When both the lower and upper actions are set, the block runs in window mode. In that mode a service is accepted only while lower limit ≤ count < upper limit. Out of reset the watchdog is already armed: it is counting, the late-service action is on, the upper limit holds its default value, and the configuration is write-protected. A lock bit guards the control, configuration and limit registers. It does not guard the service, interrupt and lock registers.

Top module: `wdog_window`

## Requirements
- R1: After reset the registers read as follows. CTRL is 0x8000_0000 (enable set). CFG is 0x10 (late-service action set). LOWER and WARN are 0. UPPER is DEF_UPPER. COUNT is 0. IRQ is 0. LOCK is 1. The outputs wdog_rst_o and wdog_irq_o are low.
- R2: While CTRL bit 31 is 1, COUNT advances by one on every cycle where tick_i is high. While CTRL bit 31 is 0, COUNT holds its value and no fault or warning is raised.
- R3: While dbg_halt_i is high, COUNT does not advance.
- R4: If CFG bit 0 is set and a SERVICE write arrives while COUNT < LOWER, then wdog_rst_o is high for exactly the next cycle and COUNT reads 0 in that cycle.
- R5: If CFG bit 4 is set and COUNT ≥ UPPER, a single one-cycle reset pulse is issued and COUNT clears. No further late-service pulse is issued until a valid service or a write to UPPER.
- R6: A SERVICE write that is not an early-service fault clears COUNT to 0 on the next edge and produces no reset. In window mode, this means any service with LOWER ≤ COUNT < UPPER.
- R7: If CFG bit 8 is set and COUNT advances onto a value equal to WARN, IRQ bit 0 becomes 1. It stays 1 until software writes 1 to IRQ bit 0.
- R8: wdog_irq_o is high exactly when IRQ bit 0 (status) and IRQ bit 1 (mask) are both 1.
- R9: While LOCK bit 0 is 1, writes to CTRL, CFG, LOWER, UPPER and WARN are ignored. SERVICE, IRQ and LOCK can always be written.
- R10: The register addresses are 0 CTRL, 1 CFG, 2 LOWER, 3 UPPER, 4 WARN, 5 COUNT, 6 SERVICE, 7 IRQ and 8 LOCK. COUNT is read-only. SERVICE and all unused addresses read as 0.
- R11: With a CFG action bit cleared, its condition has no effect. An early service then simply clears the count, and passing UPPER or WARN raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow-clock tick enable |
| dbg_halt_i | input | 1 | Freezes the counter while high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| wdog_rst_o | output | 1 | One-cycle reset request |
| wdog_irq_o | output | 1 | Masked warning interrupt |

## Verification
The bench builds the block with CNT_W = 16 and DEF_UPPER = 40. With a tick every third cycle, the default late-service expiry arrives within about 120 cycles. This lets the bench observe the single-pulse rule for late-service faults and the re-arm by service in a short run. The narrow counter keeps the limit values small, so the early, window and warning boundaries are each reached within a few dozen cycles. A behavioural model of the register file and counter is compared on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 4'd1;
  localparam logic [ADDR_W-1:0] A_LOWER = 4'd2;
  localparam logic [ADDR_W-1:0] A_UPPER = 4'd3;
  localparam logic [ADDR_W-1:0] A_WARN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd5;
  localparam logic [ADDR_W-1:0] A_SVC   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IRQ   = 4'd7;
  localparam logic [ADDR_W-1:0] A_LOCK  = 4'd8;

  localparam int B_EN    = 31;
  localparam int B_EARLY = 0;
  localparam int B_LATE  = 4;
  localparam int B_WARN  = 8;

  typedef struct packed {
    logic warn;
    logic late;
    logic early;
  } act_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_halt_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt_i && !clr_i) |=> $stable(cnt_q));
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_eval.sv
module wdog_eval
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  act_t             act_i,
  input  logic [CNT_W-1:0] lower_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic [CNT_W-1:0] warn_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             dbg_halt_i,
  input  logic             svc_stb_i,
  input  logic             upper_wr_i,
  output logic             inc_o,
  output logic             clr_o,
  output logic             warn_hit_o,
  output logic             rst_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic early, late, svc_ok;
  logic fired_q, fired_d;
  logic rst_q, rst_d;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_i + ONE;
  assign early   = svc_stb_i & en_i & act_i.early & (cnt_i < lower_i);
  assign late    = en_i & act_i.late & (cnt_i >= upper_i) & ~fired_q;
  assign svc_ok  = svc_stb_i & ~early;

  always_comb begin
    fired_d = fired_q;
    if (late)                     fired_d = 1'b1;
    else if (svc_ok | upper_wr_i) fired_d = 1'b0;
    rst_d = early | late;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      fired_q <= fired_d;
      rst_q   <= rst_d;
    end
  end

  assign inc_o      = en_i & tick_i & ~dbg_halt_i;
  assign clr_o      = early | late | svc_ok;
  assign warn_hit_o = en_i & act_i.warn & inc_o & ~clr_o & (cnt_nxt == warn_i);
  assign rst_o      = rst_q;

  // R4
  rst_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (cnt_i == '0));
  // R5
  late_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !svc_stb_i) |=> !rst_q);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] DEF_UPPER = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              warn_hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output act_t              act_o,
  output logic [CNT_W-1:0]  lower_o,
  output logic [CNT_W-1:0]  upper_o,
  output logic [CNT_W-1:0]  warn_o,
  output logic              svc_stb_o,
  output logic              upper_wr_o,
  output logic              irq_o
);
  logic             en_q, en_d;
  act_t             act_q, act_d;
  logic [CNT_W-1:0] lower_q, lower_d, upper_q, upper_d, warn_q, warn_d;
  logic             lock_q, lock_d, sts_q, sts_d, msk_q, msk_d;
  logic             wr_open;

  assign wr_open = wr_i & ~lock_q;

  always_comb begin
    en_d = en_q; act_d = act_q; lower_d = lower_q; upper_d = upper_q;
    warn_d = warn_q; lock_d = lock_q; sts_d = sts_q; msk_d = msk_q;
    if (wr_open) begin
      case (addr_i)
        A_CTRL:  en_d = wdata_i[B_EN];
        A_CFG:   act_d = '{warn: wdata_i[B_WARN], late: wdata_i[B_LATE], early: wdata_i[B_EARLY]};
        A_LOWER: lower_d = wdata_i[CNT_W-1:0];
        A_UPPER: upper_d = wdata_i[CNT_W-1:0];
        A_WARN:  warn_d = wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
    if (wr_i && addr_i == A_LOCK) lock_d = wdata_i[0];
    if (wr_i && addr_i == A_IRQ) begin
      msk_d = wdata_i[1];
      if (wdata_i[0]) sts_d = 1'b0;
    end
    if (warn_hit_i) sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      act_q   <= '{warn: 1'b0, late: 1'b1, early: 1'b0};
      lower_q <= '0;
      upper_q <= DEF_UPPER;
      warn_q  <= '0;
      lock_q  <= 1'b1;
      sts_q   <= 1'b0;
      msk_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      act_q   <= act_d;
      lower_q <= lower_d;
      upper_q <= upper_d;
      warn_q  <= warn_d;
      lock_q  <= lock_d;
      sts_q   <= sts_d;
      msk_q   <= msk_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[B_EN] = en_q;
      A_CFG: begin
        rdata_o[B_EARLY] = act_q.early;
        rdata_o[B_LATE]  = act_q.late;
        rdata_o[B_WARN]  = act_q.warn;
      end
      A_LOWER: rdata_o = DATA_W'(lower_q);
      A_UPPER: rdata_o = DATA_W'(upper_q);
      A_WARN:  rdata_o = DATA_W'(warn_q);
      A_COUNT: rdata_o = DATA_W'(cnt_i);
      A_IRQ:   rdata_o[1:0] = {msk_q, sts_q};
      A_LOCK:  rdata_o[0] = lock_q;
      default: ;
    endcase
  end

  assign en_o       = en_q;
  assign act_o      = act_q;
  assign lower_o    = lower_q;
  assign upper_o    = upper_q;
  assign warn_o     = warn_q;
  assign svc_stb_o  = wr_i & (addr_i == A_SVC);
  assign upper_wr_o = wr_open & (addr_i == A_UPPER);
  assign irq_o      = sts_q & msk_q;

  // R9
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_i && addr_i == A_CFG) |=> $stable(act_q));
  // R7
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(warn_hit_i));
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] DEF_UPPER = 'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        dbg_halt_i,
  input  logic        reg_wr_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        wdog_rst_o,
  output logic        wdog_irq_o
);
  import wdog_pkg::*;

  logic             en, svc_stb, upper_wr, inc, clr, warn_hit;
  act_t             act;
  logic [CNT_W-1:0] lower, upper, warn, cnt;

  wdog_regs #(.CNT_W(CNT_W), .DEF_UPPER(DEF_UPPER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cnt_i(cnt), .warn_hit_i(warn_hit),
    .rdata_o(reg_rdata_o), .en_o(en), .act_o(act), .lower_o(lower),
    .upper_o(upper), .warn_o(warn), .svc_stb_o(svc_stb),
    .upper_wr_o(upper_wr), .irq_o(wdog_irq_o)
  );

  wdog_eval #(.CNT_W(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .en_i(en), .act_i(act), .lower_i(lower),
    .upper_i(upper), .warn_i(warn), .cnt_i(cnt), .tick_i(tick_i),
    .dbg_halt_i(dbg_halt_i), .svc_stb_i(svc_stb), .upper_wr_i(upper_wr),
    .inc_o(inc), .clr_o(clr), .warn_hit_o(warn_hit), .rst_o(wdog_rst_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i), .inc_i(inc),
    .clr_i(clr), .cnt_o(cnt)
  );
endmodule

// File: tb/test_wdog_window.sv
`timescale 1ns/1ps
module test_wdog_window;
  localparam int W = 16;
  localparam int UP_DEF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, dbg = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = '0, rdata;
  logic rst_o, irq_o;

  always #2.5 clk = ~clk;

  wdog_window #(.CNT_W(W), .DEF_UPPER(16'(UP_DEF))) i_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_halt_i(dbg),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wdog_rst_o(rst_o), .wdog_irq_o(irq_o)
  );

  int n_run = 0, n_fail = 0, cyc = 0, rst_seen = 0;
  bit tick_on = 1'b0;

  // behavioural reference model
  int m_cnt, m_low, m_up, m_warn;
  bit m_en, m_e, m_l, m_w, m_lock, m_sts, m_msk, m_fired, m_rst;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_en ? 32'h8000_0000 : 32'h0;
      4'd1: return {23'd0, m_w, 3'd0, m_l, 3'd0, m_e};
      4'd2: return 32'(m_low);
      4'd3: return 32'(m_up);
      4'd4: return 32'(m_warn);
      4'd5: return 32'(m_cnt);
      4'd7: return {30'd0, m_msk, m_sts};
      4'd8: return {31'd0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_low = 0; m_up = UP_DEF; m_warn = 0;
      m_en = 1; m_e = 0; m_l = 1; m_w = 0; m_lock = 1;
      m_sts = 0; m_msk = 0; m_fired = 0; m_rst = 0;
    end else begin
      bit svc, early, late, ok, adv, hit, open;
      int nxt;
      svc   = wr && addr == 4'd6;
      early = svc && m_en && m_e && (m_cnt < m_low);
      late  = m_en && m_l && (m_cnt >= m_up) && !m_fired;
      ok    = svc && !early;
      adv   = m_en && tick && !dbg;
      nxt   = (m_cnt + 1) % (1 << W);
      hit   = adv && m_w && !(early || late || ok) && nxt == m_warn;
      open  = wr && !m_lock;
      m_rst = early || late;
      if (late) m_fired = 1;
      else if (ok || (open && addr == 4'd3)) m_fired = 0;
      if (early || late || ok) m_cnt = 0;
      else if (adv) m_cnt = nxt;
      if (wr && addr == 4'd7) begin
        m_msk = wdata[1];
        if (wdata[0]) m_sts = 0;
      end
      if (hit) m_sts = 1;
      if (open) begin
        case (addr)
          4'd0: m_en = wdata[31];
          4'd1: begin m_e = wdata[0]; m_l = wdata[4]; m_w = wdata[8]; end
          4'd2: m_low = int'(wdata[W-1:0]);
          4'd3: m_up = int'(wdata[W-1:0]);
          4'd4: m_warn = int'(wdata[W-1:0]);
          default: ;
        endcase
      end
      if (wr && addr == 4'd8) m_lock = wdata[0];
    end
  end

  // tick generator and per-cycle comparison
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tick = tick_on && (cyc % 3 == 0);
  end

  always @(negedge clk) if (rst_n) begin
    if (rst_o) rst_seen++;
    chk("R4 R5 reset output", {31'd0, rst_o}, {31'd0, m_rst});
    chk("R8 irq output", {31'd0, irq_o}, {31'd0, m_sts & m_msk});
    chk("R10 readback", rdata, m_read(addr));
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    step(); wr = 1'b1; addr = a; wdata = d;
    step(); wr = 1'b0; addr = 4'd5;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    addr = a; @(negedge clk); v = rdata; step();
  endtask

  task automatic wait_cnt(int v);
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(4'd5, c);
      if (c >= 32'(v)) break;
    end
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    int r0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, v); chk("R1 ctrl", v, 32'h8000_0000);
    rd(4'd1, v); chk("R1 cfg", v, 32'h10);
    rd(4'd3, v); chk("R1 upper", v, UP_DEF);
    rd(4'd8, v); chk("R1 lock", v, 1);
    rd(4'd5, v); chk("R1 count", v, 0);
    // R9 locked writes ignored
    wreg(4'd1, 32'h111); rd(4'd1, v); chk("R9 cfg locked", v, 32'h10);
    wreg(4'd2, 32'd7);   rd(4'd2, v); chk("R9 lower locked", v, 0);
    wreg(4'd8, 0);       rd(4'd8, v); chk("R9 unlock", v, 0);
    wreg(4'd1, 0);
    // R2 counting
    tick_on = 1'b1;
    repeat (30) step();
    rd(4'd5, v); chk("R2 counts", {31'd0, v > 5}, 1);
    wreg(4'd0, 0); rd(4'd5, c0); repeat (20) step();
    rd(4'd5, v); chk("R2 disabled holds", v, c0);
    wreg(4'd0, 32'h8000_0000);
    // R3 debug halt
    dbg = 1'b1; rd(4'd5, c0); repeat (20) step();
    rd(4'd5, v); chk("R3 halted", v, c0);
    dbg = 1'b0;
    // R5 late-service reset once
    wreg(4'd1, 32'h10); wreg(4'd6, 0);
    r0 = rst_seen; repeat (200) step();
    chk("R5 one late pulse", rst_seen - r0, 1);
    r0 = rst_seen; repeat (200) step();
    chk("R5 no repeat", rst_seen - r0, 0);
    // R4 early service in window mode
    wreg(4'd2, 10); wreg(4'd3, 30); wreg(4'd1, 32'h11);
    step(); wr = 1'b1; addr = 4'd6;
    step(); wr = 1'b0; addr = 4'd5;
    @(negedge clk);
    chk("R4 early pulse", {31'd0, rst_o}, 1);
    chk("R4 count cleared", rdata, 0);
    step();
    // R6 service inside window
    wait_cnt(12);
    r0 = rst_seen; wreg(4'd6, 0);
    @(negedge clk); chk("R6 window service count", rdata, 0);
    step(); chk("R6 no reset", rst_seen - r0, 0);
    // R7 R8 warning
    wreg(4'd3, 200); wreg(4'd4, 5); wreg(4'd1, 32'h110);
    wreg(4'd7, 32'h2); wreg(4'd6, 0);
    wait_cnt(8);
    rd(4'd7, v); chk("R7 status set", v, 3);
    @(negedge clk); chk("R8 irq high", {31'd0, irq_o}, 1); step();
    wreg(4'd7, 32'h3); rd(4'd7, v); chk("R7 cleared", v, 2);
    wreg(4'd7, 32'h0); wreg(4'd6, 0); wait_cnt(8);
    rd(4'd7, v); chk("R8 masked status", v, 1);
    @(negedge clk); chk("R8 irq masked", {31'd0, irq_o}, 0); step();
    // R11 actions off
    wreg(4'd7, 32'h1);
    wreg(4'd1, 0); wreg(4'd3, 20); wreg(4'd2, 10);
    r0 = rst_seen; wreg(4'd6, 0);
    wait_cnt(25); repeat (30) step();
    chk("R11 no reset", rst_seen - r0, 0);
    rd(4'd7, v); chk("R11 no warn", v, 0);
    // R10 map
    rd(4'd9, v); chk("R10 unused", v, 0);
    rd(4'd6, v); chk("R10 service reads 0", v, 0);
    tick_on = 1'b0; repeat (3) step();
    rd(4'd5, c0); wreg(4'd5, 32'h1234); rd(4'd5, v);
    chk("R10 count read-only", v, c0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule